// File: doc/BRIEF.md
# Sequencer Instruction Memory Loader

This block holds a sequencer's instruction store and lets a host fill or inspect it through a narrow byte-wide register port. The host first points at a starting word with two byte-sized address registers. It then streams bytes through one data register. Every group of four bytes, least significant first, becomes one 32-bit instruction word, and the block moves to the next word by itself. A second, wide read port lets the sequencer fetch whole instruction words at any address.

The control register holds a load-enable bit that must be set before window writes take effect. It also holds a one-shot reset bit that returns the word pointer to zero. Reads through the data window walk the memory in the same byte order as writes, so the host can verify a downloaded program without touching the address registers between words.

Register select codes: 0 = control, 1 = data window, 2 = address low byte, 3 = address high byte. Control bits: bit 0 = load enable (read/write), bit 1 = pointer reset (write-only, reads 0).

Top module: `seq_ram_loader`

## Requirements
- R1: After reset the load enable is clear, the word pointer and byte index are zero, and `reg_rdata_o` is zero.
- R2: With load enable set, four window writes store the bytes least significant first, and the word appears on the fetch port in the cycle after the fourth write's clock edge.
- R3: Memory is written only when the fourth byte of a word arrives; after one to three bytes the stored word is unchanged.
- R4: The word pointer advances by one only after the fourth byte access; after fewer bytes the address registers read back unchanged.
- R5: The word pointer is 9 bits: the low address register gives bits 7:0 and bit 0 of the high address register gives bit 8; the other high-register bits are ignored and read back as 0.
- R6: A write to either address register returns the byte index to 0, so the next window byte is byte 0 of the new word.
- R7: Window writes while load enable is clear change neither memory, the byte index, nor the word pointer.
- R8: Window reads return the current word's bytes least significant first and advance the word pointer after the fourth byte; they are allowed whether or not load enable is set.
- R9: Writing the control register with bit 1 set clears the word pointer and byte index in the same cycle that bit 0 is stored; bit 1 is not held and reads back 0.
- R10: The word pointer wraps from 511 to 0 after the fourth byte at the top word.
- R11: A register read places its value on `reg_rdata_o` one clock after the read strobe; a read strobe in the same cycle as a write strobe is ignored and `reg_rdata_o` holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_sel_i | input | 2 | Register select |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Registered read data |
| fetch_addr_i | input | 9 | Sequencer fetch word address |
| fetch_instr_o | output | 32 | Instruction word at the fetch address |

## Verification
Forty consecutive words with an arithmetic pattern, so every byte lane differs, are loaded from word 0 and compared on the fetch port; this separates byte-order swaps and off-by-one pointer steps. The same words are read back through the window to confirm the read order and pointer stepping. Interrupted words tell apart the ignored cases: words cut short by an address write, window writes with loading disabled in the middle of a word, and partial words that must not commit. The top word of memory and the high-register masking cover the pointer's width and wrap.

// File: rtl/seq_ldr_pkg.sv
package seq_ldr_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    SEL_CTRL    = 2'd0,
    SEL_DATA    = 2'd1,
    SEL_ADDR_LO = 2'd2,
    SEL_ADDR_HI = 2'd3
  } reg_sel_e;

  localparam int CTRL_LOAD_BIT = 0;
  localparam int CTRL_RST_BIT  = 1;
endpackage

// File: rtl/seq_ldr_ptr.sv
module seq_ldr_ptr #(
  parameter int ADDR_W = 9,
  parameter int BYTES  = 4,
  localparam int IDX_W = $clog2(BYTES),
  localparam int HI_W  = ADDR_W - 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              lo_we_i,
  input  logic              hi_we_i,
  input  logic [7:0]        wdata_i,
  input  logic              step_i,
  output logic [ADDR_W-1:0] word_addr_o,
  output logic [IDX_W-1:0]  byte_idx_o,
  output logic              last_o
);
  logic [ADDR_W-1:0] addr_q;
  logic [IDX_W-1:0]  idx_q;

  assign last_o      = (idx_q == IDX_W'(BYTES - 1));
  assign word_addr_o = addr_q;
  assign byte_idx_o  = idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      idx_q  <= '0;
    end else if (clr_i) begin
      addr_q <= '0;
      idx_q  <= '0;
    end else if (lo_we_i) begin
      addr_q[7:0] <= wdata_i;
      idx_q       <= '0;
    end else if (hi_we_i) begin
      addr_q[ADDR_W-1:8] <= wdata_i[HI_W-1:0];
      idx_q              <= '0;
    end else if (step_i) begin
      if (last_o) begin
        idx_q  <= '0;
        addr_q <= addr_q + ADDR_W'(1);
      end else begin
        idx_q <= idx_q + IDX_W'(1);
      end
    end
  end
endmodule

// File: rtl/seq_ldr_pack.sv
module seq_ldr_pack #(
  parameter int BYTES   = 4,
  localparam int IDX_W  = $clog2(BYTES),
  localparam int WORD_W = BYTES * 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              byte_we_i,
  input  logic [IDX_W-1:0]  byte_idx_i,
  input  logic [7:0]        wdata_i,
  output logic              commit_o,
  output logic [WORD_W-1:0] word_o
);
  logic [BYTES-2:0][7:0] stage_q;

  for (genvar g = 0; g < BYTES - 1; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[g] <= '0;
      else if (byte_we_i && byte_idx_i == IDX_W'(g)) stage_q[g] <= wdata_i;
    end
  end

  // final byte bypasses staging so the whole word lands in one write
  assign commit_o = byte_we_i && (byte_idx_i == IDX_W'(BYTES - 1));
  assign word_o   = {wdata_i, stage_q};
endmodule

// File: rtl/seq_ldr_mem.sv
module seq_ldr_mem #(
  parameter int ADDR_W = 9,
  parameter int WORD_W = 32,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_a_i,
  output logic [WORD_W-1:0] rdata_a_o,
  input  logic [ADDR_W-1:0] raddr_b_i,
  output logic [WORD_W-1:0] rdata_b_o
);
  logic [WORD_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_a_o = mem_q[raddr_a_i];
  assign rdata_b_o = mem_q[raddr_b_i];
endmodule

// File: rtl/seq_ram_loader.sv
module seq_ram_loader
  import seq_ldr_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int BYTES  = 4,
  localparam int IDX_W  = $clog2(BYTES),
  localparam int WORD_W = BYTES * BYTE_W,
  localparam int HI_W   = ADDR_W - 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        reg_sel_i,
  input  logic              reg_we_i,
  input  logic              reg_re_i,
  input  logic [7:0]        reg_wdata_i,
  output logic [7:0]        reg_rdata_o,
  input  logic [ADDR_W-1:0] fetch_addr_i,
  output logic [WORD_W-1:0] fetch_instr_o
);
  reg_sel_e          sel;
  logic              load_en;
  logic              ctrl_we, data_we, data_re, rd_go;
  logic              byte_we, step, seq_clr;
  logic [ADDR_W-1:0] word_addr;
  logic [IDX_W-1:0]  byte_idx;
  logic              last;
  logic              mem_we;
  logic [WORD_W-1:0] mem_wdata, win_word;
  logic [7:0]        win_byte, hi_rd, rd_mux;

  assign sel     = reg_sel_e'(reg_sel_i);
  assign ctrl_we = reg_we_i && sel == SEL_CTRL;
  assign data_we = reg_we_i && sel == SEL_DATA;
  assign rd_go   = reg_re_i && !reg_we_i;
  assign data_re = rd_go && sel == SEL_DATA;
  assign byte_we = data_we && load_en;
  assign step    = byte_we || data_re;
  assign seq_clr = ctrl_we && reg_wdata_i[CTRL_RST_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) load_en <= 1'b0;
    else if (ctrl_we) load_en <= reg_wdata_i[CTRL_LOAD_BIT];
  end

  seq_ldr_ptr #(.ADDR_W(ADDR_W), .BYTES(BYTES)) u_ptr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (seq_clr),
    .lo_we_i     (reg_we_i && sel == SEL_ADDR_LO),
    .hi_we_i     (reg_we_i && sel == SEL_ADDR_HI),
    .wdata_i     (reg_wdata_i),
    .step_i      (step),
    .word_addr_o (word_addr),
    .byte_idx_o  (byte_idx),
    .last_o      (last)
  );

  seq_ldr_pack #(.BYTES(BYTES)) u_pack (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .byte_we_i  (byte_we),
    .byte_idx_i (byte_idx),
    .wdata_i    (reg_wdata_i),
    .commit_o   (mem_we),
    .word_o     (mem_wdata)
  );

  seq_ldr_mem #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_mem (
    .clk_i     (clk_i),
    .we_i      (mem_we),
    .waddr_i   (word_addr),
    .wdata_i   (mem_wdata),
    .raddr_a_i (word_addr),
    .rdata_a_o (win_word),
    .raddr_b_i (fetch_addr_i),
    .rdata_b_o (fetch_instr_o)
  );

  assign win_byte = win_word[byte_idx*BYTE_W +: BYTE_W];

  always_comb begin
    hi_rd = '0;
    hi_rd[HI_W-1:0] = word_addr[ADDR_W-1:8];
  end

  always_comb begin
    unique case (sel)
      SEL_CTRL:    rd_mux = {7'd0, load_en};
      SEL_DATA:    rd_mux = win_byte;
      SEL_ADDR_LO: rd_mux = word_addr[7:0];
      default:     rd_mux = hi_rd;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) reg_rdata_o <= '0;
    else if (rd_go) reg_rdata_o <= rd_mux;
  end

  logic unused_last;
  assign unused_last = last;
endmodule

// File: rtl/seq_ram_loader_chk.sv
module seq_ram_loader_chk
  import seq_ldr_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int BYTES  = 4,
  localparam int IDX_W = $clog2(BYTES)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [1:0]        reg_sel_i,
  input logic              reg_we_i,
  input logic              reg_re_i,
  input logic [7:0]        reg_wdata_i,
  input logic              load_en,
  input logic [ADDR_W-1:0] word_addr,
  input logic [IDX_W-1:0]  byte_idx,
  input logic              mem_we
);
  logic win_wr, win_rd, win_step, at_last;
  assign win_wr   = reg_we_i && reg_sel_i == SEL_DATA;
  assign win_rd   = reg_re_i && !reg_we_i && reg_sel_i == SEL_DATA;
  assign win_step = (win_wr && load_en) || win_rd;
  assign at_last  = byte_idx == IDX_W'(BYTES - 1);

  AST_COMMIT_ONLY_FOURTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we |-> (win_wr && load_en && at_last)); // R3

  AST_ADDR_STEP_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_step && at_last) |=> word_addr == $past(word_addr) + ADDR_W'(1)); // R4

  AST_ADDR_HOLD_MID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_step && !at_last) |=> $stable(word_addr)); // R4

  AST_NO_LOAD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_wr && !load_en) |=> ($stable(word_addr) && $stable(byte_idx))); // R7

  AST_ADDR_WR_IDX_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && (reg_sel_i == SEL_ADDR_LO || reg_sel_i == SEL_ADDR_HI)) |=> byte_idx == '0); // R6

  AST_HI_BIT_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_sel_i == SEL_ADDR_HI) |=>
      word_addr[ADDR_W-1:8] == $past(reg_wdata_i[ADDR_W-9:0])); // R5

  AST_SEQ_RST_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_sel_i == SEL_CTRL && reg_wdata_i[CTRL_RST_BIT]) |=>
      (word_addr == '0 && byte_idx == '0)); // R9
endmodule

bind seq_ram_loader seq_ram_loader_chk #(.ADDR_W(ADDR_W), .BYTES(BYTES)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_sel_i   (reg_sel_i),
  .reg_we_i    (reg_we_i),
  .reg_re_i    (reg_re_i),
  .reg_wdata_i (reg_wdata_i),
  .load_en     (load_en),
  .word_addr   (word_addr),
  .byte_idx    (byte_idx),
  .mem_we      (mem_we)
);

// File: tb/seq_ram_loader_tb_top.sv
module seq_ram_loader_tb_top;
  localparam logic [1:0] S_CTRL = 2'd0, S_DATA = 2'd1, S_LO = 2'd2, S_HI = 2'd3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  sel = '0;
  logic        we = 1'b0, re = 1'b0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic [8:0]  faddr = '0;
  logic [31:0] finstr;

  int checks = 0, fails = 0;
  logic [31:0] exp_mem [512];

  always #4 clk = ~clk;

  seq_ram_loader dut_i (
    .clk_i(clk), .rst_ni(rst_n), .reg_sel_i(sel), .reg_we_i(we), .reg_re_i(re),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .fetch_addr_i(faddr), .fetch_instr_o(finstr)
  );

  function automatic logic [31:0] pat(input int i);
    return (32'(i) * 32'h9E37_79B1) ^ 32'hA5C3_0F12;
  endfunction

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk); sel = s; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] s, output logic [7:0] d);
    @(negedge clk); sel = s; re = 1'b1;
    @(negedge clk); re = 1'b0; d = rdata;
  endtask

  task automatic set_addr(input int a);
    wr(S_LO, 8'(a)); wr(S_HI, 8'(a >> 8));
  endtask

  task automatic put_word(input logic [31:0] w);
    for (int b = 0; b < 4; b++) wr(S_DATA, w[8*b +: 8]);
  endtask

  task automatic fetch(input int a, output logic [31:0] w);
    faddr = 9'(a); #1; w = finstr;
  endtask

  function automatic int cur_addr(input logic [7:0] lo, input logic [7:0] hi);
    return {hi[0], lo};
  endfunction

  task automatic summary;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    logic [7:0]  lo, hi, b8;
    logic [31:0] w;
    repeat (3) @(negedge clk);
    chk("R1 rdata after reset", 32'(rdata), 0);
    rst_n = 1'b1;
    rd(S_CTRL, b8); chk("R1 ctrl", 32'(b8), 0);
    rd(S_LO, lo);   chk("R1 addr lo", 32'(lo), 0);
    rd(S_HI, hi);   chk("R1 addr hi", 32'(hi), 0);

    // R5: only bit 0 of the high register counts
    wr(S_HI, 8'hFF); rd(S_HI, hi); chk("R5 hi 0xFF", 32'(hi), 1);
    wr(S_HI, 8'hFE); rd(S_HI, hi); chk("R5 hi 0xFE", 32'(hi), 0);
    wr(S_LO, 8'h34); rd(S_LO, lo); chk("R5 lo", 32'(lo), 32'h34);

    // R2 sweep: 40 words from address 0
    wr(S_CTRL, 8'h01);
    set_addr(0);
    for (int i = 0; i < 40; i++) begin
      put_word(pat(i)); exp_mem[i] = pat(i);
    end
    for (int i = 0; i < 40; i++) begin
      fetch(i, w); chk("R2 word store", w, exp_mem[i]);
    end
    rd(S_LO, lo); rd(S_HI, hi); chk("R4 pointer after 40 words", 32'(cur_addr(lo, hi)), 40);

    // R3/R4: partial word keeps memory and pointer
    set_addr(100); put_word(32'h1122_3344); exp_mem[100] = 32'h1122_3344;
    set_addr(100);
    wr(S_DATA, 8'hAA); wr(S_DATA, 8'hBB);
    rd(S_LO, lo); chk("R4 pointer mid-word", 32'(lo), 100);
    wr(S_DATA, 8'hCC);
    fetch(100, w); chk("R3 partial word not written", w, exp_mem[100]);
    wr(S_DATA, 8'hDD); exp_mem[100] = 32'hDDCC_BBAA;
    fetch(100, w); chk("R3 fourth byte commits", w, exp_mem[100]);

    // R6: address write restarts byte index
    wr(S_DATA, 8'h01); wr(S_DATA, 8'h02);
    set_addr(101); put_word(32'hCAFE_F00D); exp_mem[101] = 32'hCAFE_F00D;
    fetch(101, w); chk("R6 index cleared by address write", w, exp_mem[101]);
    fetch(100, w); chk("R6 previous word untouched", w, exp_mem[100]);

    // R7: disabled writes mid-word are ignored
    set_addr(50);
    wr(S_DATA, 8'h10); wr(S_DATA, 8'h20);
    wr(S_CTRL, 8'h00);
    for (int k = 0; k < 5; k++) wr(S_DATA, 8'hE0 + 8'(k));
    rd(S_LO, lo); chk("R7 pointer held while disabled", 32'(lo), 50);
    fetch(50, w); chk("R7 memory held while disabled", w, exp_mem[50]);
    wr(S_CTRL, 8'h01);
    wr(S_DATA, 8'h30); wr(S_DATA, 8'h40); exp_mem[50] = 32'h4030_2010;
    fetch(50, w); chk("R7 index held while disabled", w, exp_mem[50]);
    rd(S_LO, lo); chk("R7 pointer after resumed word", 32'(lo), 51);

    // R8: readback through the window, with loading disabled
    wr(S_CTRL, 8'h00);
    set_addr(0);
    for (int i = 0; i < 12; i++) begin
      for (int b = 0; b < 4; b++) begin
        rd(S_DATA, b8); chk("R8 window read byte", 32'(b8), 32'(exp_mem[i][8*b +: 8]));
      end
    end
    rd(S_LO, lo); chk("R8 pointer after reads", 32'(lo), 12);

    // R9: pointer reset with load enable in the same write
    rd(S_DATA, b8);
    wr(S_CTRL, 8'h03);
    rd(S_LO, lo); rd(S_HI, hi); chk("R9 pointer cleared", 32'(cur_addr(lo, hi)), 0);
    rd(S_CTRL, b8); chk("R9 ctrl reads load only", 32'(b8), 1);
    put_word(32'h0BAD_BEEF); exp_mem[0] = 32'h0BAD_BEEF;
    fetch(0, w); chk("R9 index cleared", w, exp_mem[0]);

    // R10: wrap at the top word
    set_addr(511); put_word(32'h7E57_0511); exp_mem[511] = 32'h7E57_0511;
    fetch(511, w); chk("R10 top word", w, exp_mem[511]);
    rd(S_LO, lo); rd(S_HI, hi); chk("R10 pointer wraps", 32'(cur_addr(lo, hi)), 0);

    // R11: read strobe during a write is ignored
    set_addr(9'h0A5); rd(S_LO, lo);
    @(negedge clk); sel = S_CTRL; wdata = 8'h01; we = 1'b1; re = 1'b1;
    @(negedge clk); we = 1'b0; re = 1'b0;
    chk("R11 read ignored during write", 32'(rdata), 32'(lo));
    rd(S_CTRL, b8); chk("R11 one-cycle read", 32'(b8), 1);

    summary();
  end
endmodule